// File: doc/BRIEF.md
# I/O Window Address Translator

This block bridges a processor memory bus to a legacy I/O bus whose port addresses are 16 bits wide. It claims any processor access that lands in an 8 MB window based at 0x80000000 and accepts byte, halfword or word sizes. For each claimed access it issues exactly one I/O transaction, holds the processor side waiting until the I/O side acknowledges, and then returns a one-cycle ready pulse together with the read data.

The window offset becomes a port address under one of two map modes. A mode input selects the mode. In dense mode the port is simply the low half of the bus address. In sparse mode, every 4 KB page of the window carries only 32 usable byte addresses. The five low offset bits are kept and the page number is shifted down into port bits 15:5, which packs the sparse map into the dense port space.

A swap input serves processors that expect the opposite byte order. When swapping is on, multi-byte transfers have their byte lanes reversed on the way out and again on the way back. The map mode and the swap setting are both captured when an access is accepted.

Top module: `iowin_xlate`

## Requirements
- R1: An access is claimed only when the bus address lies in 0x80000000..0x807FFFFF. For any other address, ioReq stays low and cpuReady stays low for as long as cpuSel is held.
- R2: With mapMode = 0, ioAddr equals bus address bits 15:0.
- R3: With mapMode = 1, ioAddr equals (addr AND 0x1F) OR ((addr AND 0x7FFF000) >> 7), truncated to 16 bits. That is, ioAddr[15:5] = addr[22:12] and ioAddr[4:0] = addr[4:0].
- R4: A byte access is coded cpuSize = 0 and uses lane bits 7:0. It is never swapped, and bits 31:8 of ioWdata and cpuRdata are zero.
- R5: A halfword access is coded cpuSize = 1 and uses bits 15:0, with bits 31:16 zero. When swapEn = 1 the two bytes are exchanged for writes and for reads. When swapEn = 0 they pass straight through.
- R6: A word access is coded cpuSize = 2 or 3. When swapEn = 1 all four bytes are reversed in both directions. When swapEn = 0 the data passes straight through.
- R7: Each claimed access produces exactly one ioReq assertion. It rises in the cycle after acceptance and stays high until ioAck is sampled. While it is high, ioAddr, ioWe, ioSize and ioWdata stay constant, and ioWe and ioSize follow the accepted access.
- R8: One cycle after ioAck is sampled with ioReq high, cpuReady is high for exactly one cycle and ioReq is low. cpuRdata holds the returned data during that cycle.
- R9: mapMode and swapEn are sampled when the access is accepted. Changing them while the transfer is in flight has no effect on that transfer's address or data.
- R10: While reset is active, ioReq and cpuReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuSel | input | 1 | Processor access request, held until cpuReady |
| cpuAddr | input | 32 | Processor byte address |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| cpuWdata | input | 32 | Processor write data, right-aligned |
| cpuRdata | output | 32 | Read data returned to the processor |
| cpuReady | output | 1 | One-cycle completion pulse |
| mapMode | input | 1 | 0 dense map, 1 sparse map |
| swapEn | input | 1 | 1 = reverse byte lanes of multi-byte accesses |
| ioReq | output | 1 | I/O transaction strobe, held until ioAck |
| ioWe | output | 1 | I/O direction |
| ioSize | output | 2 | I/O access size |
| ioAddr | output | 16 | I/O port address |
| ioWdata | output | 32 | I/O write data |
| ioRdata | input | 32 | I/O read data, valid with ioAck |
| ioAck | input | 1 | I/O completion acknowledge |

## Verification
The I/O request and its address, size and write data are due one clock after the processor access is accepted. Read data and cpuReady are due one clock after ioAck is sampled, and cpuReady must be gone one clock after that. The bench drives inputs on falling edges and samples at the next falling edge, so each check falls exactly one register stage after its stimulus. During acknowledge stalls of varying length it also checks at every falling edge that the request is still held. For out-of-window addresses it watches the strobe and ready lines for several falling edges.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request fields and mode settings
    logic latchRead;  // latch returned I/O read data
  } ctlStrobes_t;

  // lane alignment and optional byte reversal; size 0 byte, 1 half, else word
  function automatic logic [DATA_W-1:0] laneFix(input logic [DATA_W-1:0] d,
                                                 input logic [1:0] sz,
                                                 input logic en);
    logic [DATA_W-1:0] r;
    case (sz)
      2'd0:    r = {24'h0, d[7:0]};
      2'd1:    r = en ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
      default: r = en ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
  import iowin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuSel,
  input  logic        hit,
  input  logic        ioAck,
  output logic        ioReq,
  output logic        cpuReady,
  output ctlStrobes_t strobes
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } ctlState_e;

  ctlState_e state, stateNext;

  always_comb begin
    strobes.capture   = (state == ST_IDLE) && cpuSel && hit;
    strobes.latchRead = (state == ST_WAIT) && ioAck;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (strobes.capture)   stateNext = ST_WAIT;
      ST_WAIT: if (strobes.latchRead) stateNext = ST_RESP;
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign ioReq    = (state == ST_WAIT);
  assign cpuReady = (state == ST_RESP);

endmodule

// File: rtl/iowin_dp.sv
module iowin_dp
  import iowin_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
  parameter int WIN_BITS   = 23,
  parameter int PORT_W     = 16,
  parameter int KEEP_LOW   = 5,
  parameter int PAGE_LSB   = 12,
  parameter int FOLD_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSize,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              mapMode,
  input  logic              swapEn,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              hit,
  output logic [PORT_W-1:0] ioAddr,
  output logic              ioWe,
  output logic [1:0]        ioSize,
  output logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] cpuRdata
);

  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [WIN_BITS-1:0] offset;
  logic [PORT_W-1:0]   densePort;
  logic [PORT_W-1:0]   sparsePort;
  logic                swapHeld;

  assign hit       = (cpuAddr[ADDR_W-1 -: TAG_W] == WIN_BASE[ADDR_W-1 -: TAG_W]);
  assign offset    = cpuAddr[WIN_BITS-1:0];
  assign densePort = offset[PORT_W-1:0];

  // sparse fold: low bits kept, page bits moved down by FOLD_SHIFT
  for (genvar i = 0; i < PORT_W; i++) begin : g_fold
    localparam int SRC = i + FOLD_SHIFT;
    if (i < KEEP_LOW) begin : g_low
      assign sparsePort[i] = offset[i];
    end else if (SRC >= PAGE_LSB && SRC < WIN_BITS) begin : g_page
      assign sparsePort[i] = offset[SRC];
    end else begin : g_zero
      assign sparsePort[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioAddr   <= '0;
      ioWe     <= 1'b0;
      ioSize   <= 2'd0;
      ioWdata  <= '0;
      swapHeld <= 1'b0;
    end else if (strobes.capture) begin
      ioAddr   <= mapMode ? sparsePort : densePort;
      ioWe     <= cpuWe;
      ioSize   <= cpuSize;
      ioWdata  <= laneFix(cpuWdata, cpuSize, swapEn);
      swapHeld <= swapEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cpuRdata <= '0;
    else if (strobes.latchRead) cpuRdata <= laneFix(ioRdata, ioSize, swapHeld);
  end

endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate
  import iowin_pkg::*;
#(
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int WIN_BITS   = 23,
  parameter int PORT_W     = 16,
  parameter int KEEP_LOW   = 5,
  parameter int PAGE_LSB   = 12,
  parameter int FOLD_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic [31:0]       cpuAddr,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuReady,
  input  logic              mapMode,
  input  logic              swapEn,
  output logic              ioReq,
  output logic              ioWe,
  output logic [1:0]        ioSize,
  output logic [PORT_W-1:0] ioAddr,
  output logic [31:0]       ioWdata,
  input  logic [31:0]       ioRdata,
  input  logic              ioAck
);

  ctlStrobes_t strobes;
  logic        hit;

  iowin_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuSel   (cpuSel),
    .hit      (hit),
    .ioAck    (ioAck),
    .ioReq    (ioReq),
    .cpuReady (cpuReady),
    .strobes  (strobes)
  );

  iowin_dp #(
    .WIN_BASE   (WIN_BASE),
    .WIN_BITS   (WIN_BITS),
    .PORT_W     (PORT_W),
    .KEEP_LOW   (KEEP_LOW),
    .PAGE_LSB   (PAGE_LSB),
    .FOLD_SHIFT (FOLD_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .cpuWe    (cpuWe),
    .cpuSize  (cpuSize),
    .cpuWdata (cpuWdata),
    .mapMode  (mapMode),
    .swapEn   (swapEn),
    .strobes  (strobes),
    .ioRdata  (ioRdata),
    .hit      (hit),
    .ioAddr   (ioAddr),
    .ioWe     (ioWe),
    .ioSize   (ioSize),
    .ioWdata  (ioWdata),
    .cpuRdata (cpuRdata)
  );

endmodule

// File: rtl/iowin_xlate_chk.sv
module iowin_xlate_chk #(
  parameter logic [31:0] WIN_BASE = 32'h8000_0000,
  parameter int WIN_BITS = 23,
  parameter int PORT_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuSel,
  input logic [31:0]       cpuAddr,
  input logic              cpuReady,
  input logic              ioReq,
  input logic              ioAck,
  input logic              ioWe,
  input logic [1:0]        ioSize,
  input logic [PORT_W-1:0] ioAddr,
  input logic [31:0]       ioWdata
);

  logic inWin;
  assign inWin = (cpuAddr >= WIN_BASE) &&
                 (cpuAddr <= WIN_BASE + ((32'd1 << WIN_BITS) - 32'd1));

  // R1: an outside address never starts an I/O transaction
  p_no_strobe_outside_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !inWin && !ioReq) |=> !ioReq);

  // R7: request held until acknowledged
  p_req_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioAck) |=> ioReq);

  // R7: request fields stable while waiting
  p_req_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && !ioAck) |=> ($stable(ioAddr) && $stable(ioWdata) &&
                           $stable(ioWe) && $stable(ioSize)));

  // R8: acknowledge leads to ready and drops the request
  p_ready_after_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ioReq && ioAck) |=> (cpuReady && !ioReq));

  // R8: ready is a single-cycle pulse
  p_ready_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R8: ready only follows an acknowledged request
  p_ready_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuReady) |-> $past(ioReq && ioAck));

  // R7: strobe and ready never overlap
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(ioReq && cpuReady));

  // R10: quiet outputs under reset
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r10: assert (!ioReq && !cpuReady);
    end
  end

endmodule

bind iowin_xlate iowin_xlate_chk #(
  .WIN_BASE (WIN_BASE),
  .WIN_BITS (WIN_BITS),
  .PORT_W   (PORT_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuSel   (cpuSel),
  .cpuAddr  (cpuAddr),
  .cpuReady (cpuReady),
  .ioReq    (ioReq),
  .ioAck    (ioAck),
  .ioWe     (ioWe),
  .ioSize   (ioSize),
  .ioAddr   (ioAddr),
  .ioWdata  (ioWdata)
);

// File: tb/iowin_xlate_test.sv
module iowin_xlate_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuWe = 1'b0;
  logic [1:0]  cpuSize = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic        cpuReady;
  logic        mapMode = 1'b0;
  logic        swapEn = 1'b0;
  logic        ioReq;
  logic        ioWe;
  logic [1:0]  ioSize;
  logic [15:0] ioAddr;
  logic [31:0] ioWdata;
  logic [31:0] ioRdata = '0;
  logic        ioAck = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  int reqStarts = 0;
  logic lastReq = 1'b0;
  bit finished = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  iowin_xlate uut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuAddr(cpuAddr), .cpuWe(cpuWe),
    .cpuSize(cpuSize), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuReady(cpuReady),
    .mapMode(mapMode), .swapEn(swapEn), .ioReq(ioReq), .ioWe(ioWe), .ioSize(ioSize),
    .ioAddr(ioAddr), .ioWdata(ioWdata), .ioRdata(ioRdata), .ioAck(ioAck)
  );

  always @(negedge clk) begin
    if (ioReq === 1'b1 && lastReq !== 1'b1) reqStarts++;
    lastReq = ioReq;
  end

  function automatic logic [31:0] nextRng();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic logic [15:0] expPort(input logic [31:0] a, input logic m);
    logic [31:0] p;
    p = m ? ((a & 32'h1F) | ((a & 32'h7FFF000) >> 7)) : a;
    return p[15:0];
  endfunction

  function automatic logic [31:0] expLane(input logic [31:0] d, input logic [1:0] sz,
                                          input logic sw);
    logic [31:0] r;
    if (sz == 2'd0)      r = d & 32'hFF;
    else if (sz == 2'd1) r = sw ? (((d & 32'hFF) << 8) | ((d >> 8) & 32'hFF)) : (d & 32'hFFFF);
    else                 r = sw ? (((d & 32'hFF) << 24) | (((d >> 8) & 32'hFF) << 16) |
                                   (((d >> 16) & 32'hFF) << 8) | ((d >> 24) & 32'hFF)) : d;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string laneTag(input logic [1:0] sz);
    if (sz == 2'd0) return "R4 byte lane";
    if (sz == 2'd1) return "R5 half lane";
    return "R6 word lane";
  endfunction

  task automatic doAccess(input logic [31:0] a, input logic we, input logic [1:0] sz,
                          input logic m, input logic sw, input int delay, input bit flip);
    logic [31:0] wd, rd;
    int startCount;
    wd = nextRng();
    rd = nextRng();
    @(negedge clk);
    cpuSel = 1'b1; cpuAddr = a; cpuWe = we; cpuSize = sz; cpuWdata = wd;
    mapMode = m; swapEn = sw;
    startCount = reqStarts;
    @(negedge clk);
    check("R7 request raised", {31'b0, ioReq}, 32'd1);
    if (flip) begin
      mapMode = ~m;
      swapEn = ~sw;
    end
    check(m ? "R3 sparse port" : "R2 dense port", {16'b0, ioAddr}, {16'b0, expPort(a, m)});
    check("R7 direction", {31'b0, ioWe}, {31'b0, we});
    check("R7 size", {30'b0, ioSize}, {30'b0, sz});
    if (we) check(laneTag(sz), ioWdata, expLane(wd, sz, sw));
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      check("R7 request held", {30'b0, ioReq, cpuReady}, 32'd2);
      check(flip ? "R9 port held" : "R7 port held", {16'b0, ioAddr}, {16'b0, expPort(a, m)});
    end
    ioAck = 1'b1;
    ioRdata = rd;
    @(negedge clk);
    check("R8 ready with request dropped", {30'b0, ioReq, cpuReady}, 32'd1);
    if (!we) check(flip ? "R9 read lanes" : laneTag(sz), cpuRdata, expLane(rd, sz, sw));
    cpuSel = 1'b0;
    ioAck = 1'b0;
    ioRdata = nextRng();
    @(negedge clk);
    check("R8 ready single pulse", {31'b0, cpuReady}, 32'd0);
    check("R7 one request per access", reqStarts, startCount + 1);
  endtask

  task automatic outside(input logic [31:0] a);
    int startCount;
    @(negedge clk);
    startCount = reqStarts;
    cpuSel = 1'b1; cpuAddr = a; cpuWe = 1'b1; cpuSize = 2'd2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 no strobe outside window", {30'b0, ioReq, cpuReady}, 32'd0);
    end
    cpuSel = 1'b0;
    check("R1 no request counted", reqStarts, startCount);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {30'b0, ioReq, cpuReady}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", {30'b0, ioReq, cpuReady}, 32'd0);

    for (int m = 0; m < 2; m++)
      for (int sw = 0; sw < 2; sw++)
        for (int sz = 0; sz < 4; sz++)
          for (int we = 0; we < 2; we++)
            for (int k = 0; k < 4; k++) begin
              logic [31:0] a;
              if (k == 0)      a = 32'h8000_0000;
              else if (k == 1) a = 32'h807F_FFFF;
              else             a = 32'h8000_0000 | (nextRng() & 32'h007F_FFFF);
              doAccess(a, we[0], sz[1:0], m[0], sw[0], k % 3, k == 3);
            end

    outside(32'h8080_0000);
    outside(32'h7FFF_FFFF);
    outside(32'h0000_0000);
    outside(32'hFFFF_FFFF);
    doAccess(32'h8012_3456, 1'b0, 2'd2, 1'b1, 1'b1, 1, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule